// File: doc/BRIEF.md
# Pulse-Swallow Programmable Feedback Divider

This block divides a fast oscillator-side clock by a programmable ratio N = P·B + A and hands one pulse per divided period to a phase comparator. A behavioural dual-modulus prescaler divides the input clock by either P or P+1. Its output ticks drive two counters that run side by side. The swallow counter holds the prescaler at P+1 for the first A ticks of each period. The main counter closes the period after B ticks. A select input picks the modulus pair: 64/65 or 128/129.

The preset values and the modulus select are taken in at each period boundary. New values therefore never split a period. Either the counter-reset input or the powerdown input holds the block in its load state. While held, both counters keep reloading from the presets, the prescaler stays cleared, and both outputs stay low. When the hold is released, counting restarts from a known phase. This lets the divided output line up with a reference divider to within one prescaler cycle.

Top module: `pswl_fb_divider`

## Requirements
- R1: With the block running, successive rising edges of `div_pulse` are exactly P·B + A input clocks apart. P is 64 when `pre_sel` = 0 and 128 when `pre_sel` = 1.
- R2: Within every divided period, `mod_ctl` is high for exactly A·(P+1) input clocks. This is the first A prescaler cycles, and `mod_ctl` changes only at prescaler cycle boundaries.
- R3: `div_pulse` is high for exactly one prescaler output cycle at the end of each period. That is P clocks when A < B, and P+1 clocks when A = B.
- R4: A change of `swallow_preset`, `main_preset` or `pre_sel` made inside a period does not alter that period. It applies from the next period, whose boundary is the falling edge of `div_pulse`.
- R5: While `cnt_reset` or `pwr_down` is high, `div_pulse` and `mod_ctl` are low. Both counters are held at the presets and the prescaler is cleared.
- R6: After the hold is released, the first rising edge of `div_pulse` comes N − L clock edges after the last edge that saw the hold high. L is the length of the final prescaler cycle: P when A < B, P+1 when A = B.
- R7: Programming must satisfy 3 ≤ B ≤ 2047, A ≤ B and A < P, with A 7 bits and B 11 bits wide. The boundary settings B = 3, A = 0, A = B and A = P − 1 all divide correctly. Any load outside the legal range is flagged by an assertion.
- R8: While `rst_n` is low, `div_pulse` and `mod_ctl` are low, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-side clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 1 | Modulus select: 0 gives 64/65, 1 gives 128/129 |
| swallow_preset | input | 7 | A: number of P+1 prescaler cycles per period |
| main_preset | input | 11 | B: number of prescaler cycles per period |
| cnt_reset | input | 1 | Holds the counters in their load state |
| pwr_down | input | 1 | Powerdown; holds the counters in their load state |
| div_pulse | output | 1 | Divided output, high for the last prescaler cycle of each period |
| mod_ctl | output | 1 | Modulus control, high while the prescaler divides by P+1 |

## Verification
The assertions check several properties on every clock. The prescaler count never passes its terminal value. The swallow count never exceeds the main count. The modulus control moves only at prescaler boundaries or when the hold changes. Every hold cycle reloads the presets, and every load carries a legal triple. Other behaviours only show up in the bench's scenarios, where it counts clocks: the full divided period, the time `mod_ctl` spends high in each period, the pulse width, the restart phase after a hold, and the deferral of preset changes to the next boundary.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  localparam int unsigned PSWL_P_SMALL = 64;
  localparam int unsigned PSWL_P_LARGE = 128;
  localparam int unsigned PSWL_A_W     = 7;
  localparam int unsigned PSWL_B_W     = 11;
  localparam int unsigned PSWL_B_MIN   = 3;
endpackage

// File: rtl/pswl_prescaler.sv
module pswl_prescaler #(
  parameter int unsigned P_SMALL = 64,
  parameter int unsigned P_LARGE = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic mod_plus1,
  input  logic p_large,
  output logic tick
);
  localparam int unsigned PC_W = $clog2(P_LARGE + 2);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] term;

  // terminal count is modulus minus one, plus one more while swallowing
  always_comb begin
    term = (p_large ? PC_W'(P_LARGE - 1) : PC_W'(P_SMALL - 1)) + PC_W'(mod_plus1);
  end

  assign tick = !hold && (pc_q == term);

  always_comb begin
    if (hold || tick) pc_d = '0;
    else              pc_d = pc_q + PC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R2
  pc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |-> (pc_q <= term));
endmodule

// File: rtl/pswl_counters.sv
module pswl_counters #(
  parameter int unsigned A_W     = 7,
  parameter int unsigned B_W     = 11,
  parameter int unsigned B_MIN   = 3,
  parameter int unsigned P_SMALL = 64,
  parameter int unsigned P_LARGE = 128
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           tick,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           p_large_in,
  output logic           mod_plus1,
  output logic           p_large,
  output logic           last_cyc
);
  logic [A_W-1:0] a_q, a_d;
  logic [B_W-1:0] b_q, b_d;
  logic           p_q, p_d;
  logic           load;

  // a period closes on the tick that ends its last prescaler cycle
  assign load = hold || (tick && (b_q <= B_W'(1)));

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    p_d = p_q;
    if (load) begin
      a_d = a_in;
      b_d = b_in;
      p_d = p_large_in;
    end else if (tick) begin
      b_d = b_q - B_W'(1);
      if (a_q != '0) a_d = a_q - A_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
      p_q <= 1'b0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
      p_q <= p_d;
    end
  end

  assign mod_plus1 = !hold && (a_q != '0);
  assign last_cyc  = !hold && (b_q == B_W'(1));
  assign p_large   = p_q;

  // R7
  prog_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> ((int'(b_in) >= int'(B_MIN)) && (int'(a_in) <= int'(b_in)) &&
              (int'(a_in) < (p_large_in ? int'(P_LARGE) : int'(P_SMALL)))));

  // R7
  swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(a_q) <= int'(b_q));

  // R5
  load_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hold) && $past(rst_n)) |->
      ((a_q == $past(a_in)) && (b_q == $past(b_in)) && (p_q == $past(p_large_in))));

  // R2
  mod_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(tick) && !$past(hold) && !hold) |-> $stable(mod_plus1));
endmodule

// File: rtl/pswl_fb_divider.sv
module pswl_fb_divider
  import pswl_pkg::*;
#(
  parameter int unsigned P_SMALL = PSWL_P_SMALL,
  parameter int unsigned P_LARGE = PSWL_P_LARGE,
  parameter int unsigned A_W     = PSWL_A_W,
  parameter int unsigned B_W     = PSWL_B_W,
  parameter int unsigned B_MIN   = PSWL_B_MIN
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_sel,
  input  logic [A_W-1:0] swallow_preset,
  input  logic [B_W-1:0] main_preset,
  input  logic           cnt_reset,
  input  logic           pwr_down,
  output logic           div_pulse,
  output logic           mod_ctl
);
  logic hold;
  logic tick;
  logic mod_plus1;
  logic p_large;
  logic last_cyc;

  assign hold = cnt_reset | pwr_down;

  pswl_prescaler #(
    .P_SMALL (P_SMALL),
    .P_LARGE (P_LARGE)
  ) u_prescaler (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .mod_plus1 (mod_plus1),
    .p_large   (p_large),
    .tick      (tick)
  );

  pswl_counters #(
    .A_W     (A_W),
    .B_W     (B_W),
    .B_MIN   (B_MIN),
    .P_SMALL (P_SMALL),
    .P_LARGE (P_LARGE)
  ) u_counters (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .tick       (tick),
    .a_in       (swallow_preset),
    .b_in       (main_preset),
    .p_large_in (pre_sel),
    .mod_plus1  (mod_plus1),
    .p_large    (p_large),
    .last_cyc   (last_cyc)
  );

  assign div_pulse = last_cyc;
  assign mod_ctl   = mod_plus1;
endmodule

// File: tb/pswl_fb_divider_tb.sv
module pswl_fb_divider_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pre_sel;
  logic [6:0]  swallow_preset;
  logic [10:0] main_preset;
  logic        cnt_reset;
  logic        pwr_down;
  logic        div_pulse;
  logic        mod_ctl;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pswl_fb_divider u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .pre_sel        (pre_sel),
    .swallow_preset (swallow_preset),
    .main_preset    (main_preset),
    .cnt_reset      (cnt_reset),
    .pwr_down       (pwr_down),
    .div_pulse      (div_pulse),
    .mod_ctl        (mod_ctl)
  );

  // {pre_sel, A, B}
  localparam int NVEC = 7;
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 7'd0,   11'd3},
    {1'b0, 7'd5,   11'd10},
    {1'b1, 7'd7,   11'd12},
    {1'b0, 7'd20,  11'd20},
    {1'b0, 7'd63,  11'd63},
    {1'b1, 7'd127, 11'd130},
    {1'b1, 7'd0,   11'd5}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic sel, input int a, input int b);
    pre_sel        = sel;
    swallow_preset = 7'(a);
    main_preset    = 11'(b);
  endtask

  // steps negedges until the next rising (rise=1) or falling edge of div_pulse
  task automatic next_edge(input bit rise, output int n, output int mods, output int highs);
    logic prev;
    n = 0; mods = 0; highs = 0;
    prev = div_pulse;
    forever begin
      @(negedge clk);
      n++;
      if (mod_ctl)   mods++;
      if (div_pulse) highs++;
      if (rise ? (div_pulse && !prev) : (!div_pulse && prev)) break;
      prev = div_pulse;
      if (n > 60000) begin
        n_chk++; n_fail++;
        $display("FAIL timeout waiting for edge: actual %0d expected <= 60000", n);
        break;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 190000 cycles expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, mods, highs, pp, nn, last;
    rst_n = 1'b0; cnt_reset = 1'b1; pwr_down = 1'b0;
    apply(1'b0, 0, 3);
    repeat (4) @(negedge clk);
    // R8 reset state
    check("R8", "div_pulse in reset", int'(div_pulse), 0);
    check("R8", "mod_ctl in reset",   int'(mod_ctl),   0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      logic [18:0] v;
      logic        sel;
      int          a, b;
      v   = VEC[i];
      sel = v[18];
      a   = int'(v[17:11]);
      b   = int'(v[10:0]);
      pp  = sel ? 128 : 64;
      nn  = pp * b + a;
      last = (a == b) ? pp + 1 : pp;
      cnt_reset = 1'b1;
      apply(sel, a, b);
      repeat (3) @(negedge clk);
      check("R5", "div_pulse under cnt_reset", int'(div_pulse), 0);
      check("R5", "mod_ctl under cnt_reset",   int'(mod_ctl),   0);
      cnt_reset = 1'b0;
      next_edge(1'b1, n, mods, highs);
      check("R6", "first rise after release", n, nn - last);
      for (int k = 0; k < 2; k++) begin
        next_edge(1'b1, n, mods, highs);
        check((b == 3 || a == 0 || a == b || a == pp - 1) ? "R1 R7" : "R1", "period", n, nn);
        check("R2", "mod_ctl high clocks per period", mods, a * (pp + 1));
        check("R3", "div_pulse width", highs, last);
      end
    end

    // R4: presets changed inside a period apply from the next one
    cnt_reset = 1'b1;
    apply(1'b0, 3, 6);
    repeat (2) @(negedge clk);
    cnt_reset = 1'b0;
    next_edge(1'b0, n, mods, highs);
    apply(1'b1, 10, 12);
    next_edge(1'b0, n, mods, highs);
    check("R4", "period in progress keeps old ratio", n, 64 * 6 + 3);
    next_edge(1'b0, n, mods, highs);
    check("R4", "following period uses new ratio", n, 128 * 12 + 10);

    // R5: powerdown mid-period returns counters to load state
    repeat (100) @(negedge clk);
    pwr_down = 1'b1;
    repeat (5) @(negedge clk);
    check("R5", "div_pulse under pwr_down", int'(div_pulse), 0);
    check("R5", "mod_ctl under pwr_down",   int'(mod_ctl),   0);
    pwr_down = 1'b0;
    next_edge(1'b1, n, mods, highs);
    check("R5 R6", "first rise after powerdown", n, 128 * 12 + 10 - 128);

    // R8: asynchronous reset mid-run
    repeat (37) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5;
    check("R8", "div_pulse after async reset", int'(div_pulse), 0);
    check("R8", "mod_ctl after async reset",   int'(mod_ctl),   0);
    @(negedge clk);
    cnt_reset = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule